// File: doc/BRIEF.md
# Pad Calibration Sequencer

This block is the control plane for calibrating a set of high-speed serial pad groups. Software reaches it over a simple 32-bit register bus, where each register is addressed by a word index. Through that bus it programs per-pad offset values for data lanes and for clock lanes, sets the bias-pad settings, and then writes a start bit. That start bit launches a timed calibration sequence.

The sequence holds an active flag for a fixed number of clock cycles. The cycle count is a base count multiplied by a power of two, and a prescale field picks that power. When the sequence ends, the block raises a sticky done flag and emits a one-cycle completion pulse. In the same step it copies the offsets of every pad whose select bit is set onto that pad's output port. The analog comparators, the impedance search and the regulators sit outside the block. The bias registers are only held here for their neighbours to read.

Software treats a run as finished when the status register shows active low and done high. It then clears done by writing a one to the done bit.

Top module: `padcal_seq`

## Requirements
- R1: After reset every register reads zero, active and done are low, the completion pulse is low and all pad offset outputs are zero.
- R2: Register indices are: control 0x00, status 0x02, bias 0x16/0x17/0x18, data-lane pads from 0x05 upward (one per pad), clock-lane pads from 0x19 upward. Only these bits are writable: control 0x3F000011, data pad 0x003F1F1F, clock pad 0x00201F1F, bias0 0x00000003, bias1 0x00070700, bias2 0x00070072. All other bits read zero, and any other index reads zero.
- R3: Writing bit 0 of control while idle makes it read 1 for one cycle. On the next clock edge it reads 0 and active (status bit 0) goes high.
- R4: Active stays high for exactly BASE_CYCLES * 2^(P+1) cycles, where P is control bits 25:24 as they stood in the launch cycle. Later writes to P do not change a run in progress.
- R5: At the end of a run active falls and done (status bit 16) rises together. The completion pulse is high for exactly that first cycle, and status then reads 0x00010000.
- R6: A start write while active is high is ignored. The run keeps its length, and no second run follows.
- R7: Done clears only when status is written with bit 16 set. Writing 0, or writing bit 0 alone, leaves it set. Active cannot be written.
- R8: Launching a run clears done, so done reads 0 while active is high.
- R9: At completion each data pad with bit 21 set outputs {bits 20:16, 12:8, 4:0} as a 15-bit value, most significant field first. Each clock pad with bit 21 set outputs {bits 12:8, 4:0} as a 10-bit value.
- R10: A pad whose bit 21 is clear at completion keeps its previous output.
- R11: Writes to pad configuration registers while active is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx (combinational, zero when bus_sel is low) |
| cal_active_o | output | 1 | Calibration run in progress |
| cal_done_o | output | 1 | Sticky completion flag |
| cal_done_pulse_o | output | 1 | One-cycle pulse in the first cycle after a run |
| data_ofs_o | output | 15*N_DATA | Latched data-lane offsets, pad i at bits 15*i+14:15*i |
| clk_ofs_o | output | 10*N_CLK | Latched clock-lane offsets, pad j at bits 10*j+9:10*j |

## Verification
The assertions assume at most one bus access per cycle, and bus inputs that are stable around the rising edge. They also assume BASE_CYCLES is at least one, so every run has a finite, non-zero length. The done-clear property is not checked in the completion cycle, because there a finishing run takes priority over a clearing write. The stimulus changes the bus only on falling edges and issues one request at a time. Its single mid-run injection of a start write and a pad write falls well inside the shortest run.

// File: rtl/padcal_pkg.sv
package padcal_pkg;

  localparam int unsigned IDX_CTRL   = 32'h00;
  localparam int unsigned IDX_STAT   = 32'h02;
  localparam int unsigned IDX_DATA0  = 32'h05;
  localparam int unsigned IDX_BIAS0  = 32'h16;
  localparam int unsigned IDX_CLK0   = 32'h19;
  localparam int unsigned N_BIAS     = 3;

  localparam int unsigned SEL_BIT    = 21;
  localparam int unsigned STAT_DONE  = 16;

  localparam logic [31:0] CTRL_MASK  = 32'h3F00_0011;
  localparam logic [31:0] DATA_MASK  = 32'h003F_1F1F;
  localparam logic [31:0] CLKL_MASK  = 32'h0020_1F1F;

  function automatic logic [31:0] bias_mask(input int unsigned k);
    case (k)
      0:       return 32'h0000_0003;
      1:       return 32'h0007_0700;
      default: return 32'h0007_0072;
    endcase
  endfunction

  // Run length in cycles for a given prescale code.
  function automatic int unsigned cal_cycles(input int unsigned base,
                                             input logic [1:0] ps);
    return base << (int'(ps) + 1);
  endfunction

  function automatic logic [14:0] pack_data(input logic [31:0] r);
    return {r[20:16], r[12:8], r[4:0]};
  endfunction

  function automatic logic [9:0] pack_clk(input logic [31:0] r);
    return {r[12:8], r[4:0]};
  endfunction

endpackage

// File: rtl/padcal_regs.sv
module padcal_regs #(
  parameter int unsigned N_DATA = 4,
  parameter int unsigned N_CLK  = 2,
  parameter int unsigned IDX_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [IDX_W-1:0]        bus_idx,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    active,
  input  logic                    launch,
  input  logic                    finish,
  output logic                    done,
  output logic                    start_bit,
  output logic [1:0]              prescale,
  output logic [N_DATA-1:0][31:0] data_cfg,
  output logic [N_CLK-1:0][31:0]  clk_cfg
);
  import padcal_pkg::*;

  logic        wr;
  logic [31:0] ctrl;
  logic [N_BIAS-1:0][31:0] bias;
  logic [31:0] rd;
  logic        hit_ctrl, hit_stat;

  assign wr       = bus_sel & bus_we;
  assign hit_ctrl = (bus_idx == IDX_W'(IDX_CTRL));
  assign hit_stat = (bus_idx == IDX_W'(IDX_STAT));

  assign start_bit = ctrl[0];
  assign prescale  = ctrl[25:24];

  // Control: start bit cannot be set while a run is active; launch clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr && hit_ctrl) begin
        ctrl    <= bus_wdata & CTRL_MASK;
        ctrl[0] <= bus_wdata[0] & ~active;
      end
      if (launch) ctrl[0] <= 1'b0;
    end
  end

  // Sticky done: completion sets, launch or write-one clears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else if (finish) begin
      done <= 1'b1;
    end else if (launch) begin
      done <= 1'b0;
    end else if (wr && hit_stat && bus_wdata[STAT_DONE]) begin
      done <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias <= '0;
    end else begin
      for (int k = 0; k < int'(N_BIAS); k++) begin
        if (wr && bus_idx == IDX_W'(IDX_BIAS0 + k))
          bias[k] <= bus_wdata & bias_mask(k);
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < int'(N_DATA); gi++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          data_cfg[gi] <= '0;
        else if (wr && !active && bus_idx == IDX_W'(IDX_DATA0 + gi))
          data_cfg[gi] <= bus_wdata & DATA_MASK;
      end
    end
    for (gi = 0; gi < int'(N_CLK); gi++) begin : g_clk
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          clk_cfg[gi] <= '0;
        else if (wr && !active && bus_idx == IDX_W'(IDX_CLK0 + gi))
          clk_cfg[gi] <= bus_wdata & CLKL_MASK;
      end
    end
  endgenerate

  always_comb begin
    rd = '0;
    if (hit_ctrl) rd = ctrl;
    if (hit_stat) rd = {15'd0, done, 15'd0, active};
    for (int k = 0; k < int'(N_BIAS); k++)
      if (bus_idx == IDX_W'(IDX_BIAS0 + k)) rd = bias[k];
    for (int i = 0; i < int'(N_DATA); i++)
      if (bus_idx == IDX_W'(IDX_DATA0 + i)) rd = data_cfg[i];
    for (int j = 0; j < int'(N_CLK); j++)
      if (bus_idx == IDX_W'(IDX_CLK0 + j)) rd = clk_cfg[j];
    bus_rdata = bus_sel ? rd : 32'd0;
  end

endmodule

// File: rtl/padcal_timer.sv
module padcal_timer #(
  parameter int unsigned BASE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_bit,
  input  logic [1:0] prescale,
  output logic       active,
  output logic       launch,
  output logic       finish,
  output logic       done_pulse
);
  import padcal_pkg::*;

  localparam int unsigned MAX_LEN = BASE_CYCLES << 4;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] remain;

  assign launch = start_bit & ~active;
  assign finish = active & (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      remain     <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= finish;
      if (launch) begin
        active <= 1'b1;
        remain <= CNT_W'(cal_cycles(BASE_CYCLES, prescale) - 1);
      end else if (finish) begin
        active <= 1'b0;
      end else if (active) begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/padcal_apply.sv
module padcal_apply #(
  parameter int unsigned N_DATA = 4,
  parameter int unsigned N_CLK  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    finish,
  input  logic [N_DATA-1:0][31:0] data_cfg,
  input  logic [N_CLK-1:0][31:0]  clk_cfg,
  output logic [15*N_DATA-1:0]    data_ofs,
  output logic [10*N_CLK-1:0]     clk_ofs
);
  import padcal_pkg::*;

  genvar gi;
  generate
    for (gi = 0; gi < int'(N_DATA); gi++) begin : g_data
      logic [14:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (finish && data_cfg[gi][SEL_BIT])
          q <= pack_data(data_cfg[gi]);
      end
      assign data_ofs[15*gi +: 15] = q;
    end
    for (gi = 0; gi < int'(N_CLK); gi++) begin : g_clk
      logic [9:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (finish && clk_cfg[gi][SEL_BIT])
          q <= pack_clk(clk_cfg[gi]);
      end
      assign clk_ofs[10*gi +: 10] = q;
    end
  endgenerate

endmodule

// File: rtl/padcal_seq.sv
module padcal_seq #(
  parameter int unsigned N_DATA      = 4,
  parameter int unsigned N_CLK       = 2,
  parameter int unsigned BASE_CYCLES = 8,
  parameter int unsigned IDX_W       = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [IDX_W-1:0]     bus_idx,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 cal_active_o,
  output logic                 cal_done_o,
  output logic                 cal_done_pulse_o,
  output logic [15*N_DATA-1:0] data_ofs_o,
  output logic [10*N_CLK-1:0]  clk_ofs_o
);

  logic                    launch_w;
  logic                    finish_w;
  logic                    start_w;
  logic [1:0]              prescale_w;
  logic [N_DATA-1:0][31:0] data_cfg_w;
  logic [N_CLK-1:0][31:0]  clk_cfg_w;

  padcal_regs #(.N_DATA(N_DATA), .N_CLK(N_CLK), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .active    (cal_active_o),
    .launch    (launch_w),
    .finish    (finish_w),
    .done      (cal_done_o),
    .start_bit (start_w),
    .prescale  (prescale_w),
    .data_cfg  (data_cfg_w),
    .clk_cfg   (clk_cfg_w)
  );

  padcal_timer #(.BASE_CYCLES(BASE_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_bit  (start_w),
    .prescale   (prescale_w),
    .active     (cal_active_o),
    .launch     (launch_w),
    .finish     (finish_w),
    .done_pulse (cal_done_pulse_o)
  );

  padcal_apply #(.N_DATA(N_DATA), .N_CLK(N_CLK)) u_apply (
    .clk      (clk),
    .rst_n    (rst_n),
    .finish   (finish_w),
    .data_cfg (data_cfg_w),
    .clk_cfg  (clk_cfg_w),
    .data_ofs (data_ofs_o),
    .clk_ofs  (clk_ofs_o)
  );

endmodule

// File: rtl/padcal_checker.sv
module padcal_checker #(
  parameter int unsigned BASE_CYCLES = 8,
  parameter int unsigned IDX_W       = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             done,
  input logic             pulse,
  input logic             launch,
  input logic             finish,
  input logic             start_bit,
  input logic [1:0]       prescale,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [IDX_W-1:0] bus_idx,
  input logic             wdata_done
);

  logic [31:0] run_cnt;
  logic [31:0] run_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_exp <= '0;
    end else if (launch) begin
      run_cnt <= '0;
      run_exp <= BASE_CYCLES << (int'(prescale) + 1);
    end else if (active) begin
      run_cnt <= run_cnt + 1;
    end
  end

  // R3: a launch leaves the start bit clear and active high
  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (active && !start_bit));

  // R4: run length measured independently of the timer
  assert_run_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (run_cnt == run_exp));

  // R5: end of run raises done and the pulse together
  assert_fall_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (done && pulse));

  // R5: completion pulse lasts one cycle
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R8: done is low once a run has started
  assert_done_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !done);

  // R7: write-one to the done bit clears it unless a run finishes then
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_idx == IDX_W'(2) && wdata_done && !finish)
      |=> !done);

endmodule

bind padcal_seq padcal_checker #(.BASE_CYCLES(BASE_CYCLES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (cal_active_o),
  .done       (cal_done_o),
  .pulse      (cal_done_pulse_o),
  .launch     (launch_w),
  .finish     (finish_w),
  .start_bit  (start_w),
  .prescale   (prescale_w),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_idx    (bus_idx),
  .wdata_done (bus_wdata[16])
);

// File: tb/padcal_seq_bench.sv
module padcal_seq_bench;
  localparam int ND   = 4;
  localparam int NC   = 2;
  localparam int BASE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_we = 1'b0;
  logic [5:0] bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic active, done, pulse;
  logic [15*ND-1:0] data_ofs;
  logic [10*NC-1:0] clk_ofs;

  int checks = 0;
  int failures = 0;
  int exp_d [ND];
  int exp_c [NC];

  always #2 clk = ~clk;

  padcal_seq #(.N_DATA(ND), .N_CLK(NC), .BASE_CYCLES(BASE), .IDX_W(6)) u_padcal_seq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cal_active_o(active), .cal_done_o(done), .cal_done_pulse_o(pulse),
    .data_ofs_o(data_ofs), .clk_ofs_o(clk_ofs)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_idx = 6'(idx); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_idx = 6'(idx);
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] wmask(input int idx);
    if (idx == 0) return 32'h3F00_0011;
    if (idx >= 5 && idx < 5 + ND) return 32'h003F_1F1F;
    if (idx >= 25 && idx < 25 + NC) return 32'h0020_1F1F;
    if (idx == 22) return 32'h0000_0003;
    if (idx == 23) return 32'h0007_0700;
    if (idx == 24) return 32'h0007_0072;
    return 32'h0;
  endfunction

  // Launch a run and measure it; optionally inject a start and a pad write mid-run.
  task automatic run_cal(input int ps, input bit inject, output int len, output int pulses);
    logic [31:0] r;
    int post;
    bit seen;
    bus_write(0, (32'(ps) << 24) | 32'h1);
    bus_read(0, r);
    check("R3", "start bit before launch", {31'd0, r[0]}, 32'd1);
    len = 0; pulses = 0; post = 0; seen = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (k == 1) begin
        bus_read(0, r);
        check("R3", "start bit self-clears", {31'd0, r[0]}, 32'd0);
        bus_read(2, r);
        check("R8", "status during run", r, 32'h0000_0001);
      end
      if (inject && k == 3) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_idx = 6'd0; bus_wdata = 32'h0000_0001;
      end
      if (inject && k == 4) begin
        bus_idx = 6'd5; bus_wdata = 32'h0;
      end
      if (inject && k == 5) begin
        bus_sel = 1'b0; bus_we = 1'b0;
      end
      if (active) begin len++; seen = 1; end
      if (pulse) pulses++;
      if (seen && !active) post++;
      if (post == 4) break;
    end
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < ND; i++)
      check(tag, $sformatf("data pad %0d", i), 32'(data_ofs[15*i +: 15]), 32'(exp_d[i]));
    for (int j = 0; j < NC; j++)
      check(tag, $sformatf("clk pad %0d", j), 32'(clk_ofs[10*j +: 10]), 32'(exp_c[j]));
  endtask

  initial begin
    bit timeout;
    timeout = 0;
    fork
      begin
        repeat (200000) @(posedge clk);
        timeout = 1;
      end
      begin
        logic [31:0] r;
        int len, pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int idx = 0; idx < 64; idx++) begin
          bus_read(idx, r);
          check("R1", $sformatf("reset read idx %0d", idx), r, 32'h0);
        end
        check("R1", "reset flags", {29'd0, active, done, pulse}, 32'h0);
        for (int i = 0; i < ND; i++) exp_d[i] = 0;
        for (int j = 0; j < NC; j++) exp_c[j] = 0;
        check_outputs("R1");

        // R2: write all ones everywhere except control, read back masks
        for (int idx = 1; idx < 64; idx++) begin
          bus_write(idx, 32'hFFFF_FFFF);
          bus_read(idx, r);
          check("R2", $sformatf("mask idx %0d", idx), r, wmask(idx));
        end
        bus_write(0, 32'hFFFF_FFFE);
        bus_read(0, r);
        check("R2", "control mask", r, 32'h3F00_0010);
        check("R2", "no run from masked write", {31'd0, active}, 32'd0);
        for (int idx = 0; idx < 64; idx++) bus_write(idx, 32'h0);

        // R4 R5 R8 R9 R10: runs at every prescale with varying selections
        for (int ps = 0; ps < 4; ps++) begin
          for (int i = 0; i < ND; i++) begin
            int a, b, c, sel;
            sel = (ps == 3) || (((i + ps) % 2) == 0);
            a = (i * 7 + ps * 3 + 1) % 32;
            b = (i * 5 + ps + 2) % 32;
            c = (i * 3 + ps * 11 + 4) % 32;
            bus_write(5 + i, (32'(sel) << 21) | (32'(a) << 16) | (32'(b) << 8) | 32'(c));
            if (sel != 0) exp_d[i] = a * 1024 + b * 32 + c;
          end
          for (int j = 0; j < NC; j++) begin
            int b, c, sel;
            sel = (ps == 3) || (((j + ps) % 2) == 1);
            b = (j * 9 + ps * 5 + 3) % 32;
            c = (j * 13 + ps * 7 + 6) % 32;
            bus_write(25 + j, (32'(sel) << 21) | (32'(b) << 8) | 32'(c));
            if (sel != 0) exp_c[j] = b * 32 + c;
          end
          run_cal(ps, 1'b0, len, pulses);
          check("R4", $sformatf("run length ps=%0d", ps), 32'(len), 32'(BASE << (ps + 1)));
          check("R5", "one completion pulse", 32'(pulses), 32'd1);
          bus_read(2, r);
          check("R5", "status after run", r, 32'h0001_0000);
          check_outputs(ps == 3 ? "R9" : "R10");
        end

        // R6 R11: start and pad writes while active are ignored
        bus_read(5, r);
        run_cal(1, 1'b1, len, pulses);
        check("R6", "length unchanged by start during run", 32'(len), 32'(BASE << 2));
        check("R6", "no second run", {31'd0, active}, 32'd0);
        check("R6", "single pulse", 32'(pulses), 32'd1);
        begin
          logic [31:0] r2;
          bus_read(5, r2);
          check("R11", "pad write during run ignored", r2, r);
        end
        bus_read(0, r);
        check("R6", "start bit clear after run", {31'd0, r[0]}, 32'd0);
        check_outputs("R9");

        // R7: write-one-to-clear on done only
        bus_write(2, 32'h0);
        bus_read(2, r);
        check("R7", "write zero keeps done", r, 32'h0001_0000);
        bus_write(2, 32'h1);
        bus_read(2, r);
        check("R7", "active not writable", r, 32'h0001_0000);
        bus_write(2, 32'h0001_0000);
        bus_read(2, r);
        check("R7", "done cleared", r, 32'h0);
        check("R7", "done port low", {31'd0, done}, 32'd0);
      end
    join_any
    if (timeout) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule